// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a 16-bit down-counting timer that produces one pulse per trigger. Software loads a reload value, selects the one-shot mode and a trigger source in a small configuration register, and sets a run bit. A trigger is either a software strobe or an edge on an asynchronous external pin. A trigger is held pending until the next pulse of the count-source enable `tick`, so the pulse is always aligned to the count source. On that tick the counter takes the reload value and the pulse output goes high. Each later tick counts it down. When the count reaches zero the pulse ends and the interrupt request flag is raised.

A trigger that arrives during a pulse restarts the pulse. Clearing the run bit aborts the pulse and raises the flag one clock later. A cutoff input can force the pulse pad into high impedance, which is signalled through an output enable. A live view of the counter is always available for read-back. All pins are plain control and status wires. There is no streaming interface and no back-pressure.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the pulse output is low, the interrupt flag is low, the counter view is 0 and the configuration mode field is timer (00). While the run bit is 0, neither triggers nor ticks start a pulse.
- R2: Configuration writes (bits [1:0] mode: 00 timer, 01 event, 10 one-shot, 11 reserved; bit 2 trigger source; bit 3 cutoff enable) are accepted only while the run bit is 0. A write while running changes nothing.
- R3: Writing 0 to the run bit while it is 1 copies the reload value into the counter and drives the pulse low at the next clock. In one-shot mode it also sets the interrupt flag one clock after that.
- R4: A trigger starts the pulse only on a cycle with `tick` high, so the pulse lags the trigger by up to one count-source period. The external pin passes through a two-stage synchronizer and a rising-edge detector first.
- R5: A started pulse loads the reload value N and stays high for N ticks (at least one). On the tick that takes the count from 1 to 0, the pulse goes low, the counter shows 0 and the interrupt flag is set.
- R6: A configuration write that changes the mode field from a non-one-shot code to 10 sets the interrupt flag. Rewriting 10 while already in one-shot mode does not.
- R7: The counter view reads 0xFFFF in any cycle in which a reload takes effect at the next edge (pulse start, retrigger reload, stop). After a reload write while stopped, the view shows the written value from the next cycle.
- R8: A trigger during a pulse makes the next tick count down once. The tick after that reloads N and counting continues. A trigger arriving before that second tick is ignored.
- R9: `irq_clr` clears the interrupt flag at the next edge. A hardware set in the same cycle wins over the clear.
- R10: With cutoff enabled (bit 3 = 1) and `cut_n` low, `pulse_oe` is 0 (pad high impedance). Otherwise it is 1.
- R11: With bit 2 = 0 only `sw_trig` triggers. With bit 2 = 1 only the external pin triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration data: cutoff enable, trigger source, mode |
| run_we | input | 1 | Run bit write strobe |
| run_wdata | input | 1 | New run bit value |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload value |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| tick | input | 1 | Count-source enable, one clock wide |
| cut_n | input | 1 | Active-low cutoff request |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| cnt_view | output | 16 | Live counter read-back |
| pulse_o | output | 1 | Pulse output level |
| pulse_oe | output | 1 | Pulse pad output enable |
| irq_o | output | 1 | Interrupt request flag |

## Verification
Two functions can land on the interrupt flag in the same cycle: the software clear, and a hardware set from the stop sequence. The bench aborts a running pulse and raises `irq_clr` in exactly the cycle in which the delayed stop set lands, then expects the flag high. Retriggering is provoked with a second software trigger inside the blanking window, and is judged by whether the counter resumes from the reload value or from one step lower.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  localparam int CNT_W  = 16;
  localparam int CFG_W  = 4;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'b00,
    MODE_EVENT   = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_RSVD    = 2'b11
  } mode_e;

  typedef struct packed {
    logic  cut_en;
    logic  trig_ext;
    mode_e mode;
  } cfg_t;
endpackage

// File: rtl/os_trig_sync.sv
module os_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/os_irq_flag.sv
module os_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/os_count_core.sv
module os_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         stop_i,
  input  logic         trig_i,
  input  logic         tick_i,
  input  logic         rld_we_i,
  input  logic [W-1:0] rld_wdata_i,
  output logic [W-1:0] view_o,
  output logic         active_o,
  output logic         zero_end_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, rld_q, dec;
  logic active_q, pend_q, blank_q, rldue_q;
  logic trig_take, reload_now;

  assign dec        = (cnt_q == '0) ? '0 : cnt_q - ONE;
  assign trig_take  = run_i && trig_i && !pend_q && !blank_q;
  assign zero_end_o = run_i && !stop_i && tick_i && !rldue_q && !pend_q &&
                      active_q && (cnt_q <= ONE);
  assign reload_now = stop_i ||
                      (run_i && tick_i && (rldue_q || (pend_q && !active_q)));
  assign view_o     = reload_now ? '1 : cnt_q;
  assign active_o   = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rld_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      blank_q  <= 1'b0;
      rldue_q  <= 1'b0;
    end else begin
      if (rld_we_i) rld_q <= rld_wdata_i;
      if (stop_i) begin
        cnt_q    <= rld_q;
        active_q <= 1'b0;
        pend_q   <= 1'b0;
        blank_q  <= 1'b0;
        rldue_q  <= 1'b0;
      end else if (!run_i) begin
        if (rld_we_i) cnt_q <= rld_wdata_i;
      end else begin
        if (trig_take) pend_q <= 1'b1;
        if (tick_i) begin
          blank_q <= 1'b0;
          rldue_q <= 1'b0;
          if (rldue_q) begin
            cnt_q <= rld_q;
          end else if (pend_q) begin
            pend_q  <= 1'b0;
            blank_q <= 1'b1;
            if (active_q) begin
              cnt_q   <= dec;
              rldue_q <= 1'b1;
            end else begin
              cnt_q    <= rld_q;
              active_q <= 1'b1;
            end
          end else if (active_q) begin
            cnt_q <= dec;
            if (cnt_q <= ONE) active_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int W           = CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             run_we,
  input  logic             run_wdata,
  input  logic             reload_we,
  input  logic [W-1:0]     reload_wdata,
  input  logic             sw_trig,
  input  logic             ext_trig,
  input  logic             tick,
  input  logic             cut_n,
  input  logic             irq_clr,
  output logic [W-1:0]     cnt_view,
  output logic             pulse_o,
  output logic             pulse_oe,
  output logic             irq_o
);
  cfg_t cfg_q, cfg_new;
  logic run_q, stop_evt, stop_d, run_eff;
  logic ext_rise, trig_sel, zero_end, mode_enter, irq_set;

  assign cfg_new  = cfg_t'(cfg_wdata);
  assign stop_evt = run_we && !run_wdata && run_q;
  assign run_eff  = run_q && (cfg_q.mode == MODE_ONESHOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{cut_en: 1'b0, trig_ext: 1'b0, mode: MODE_TIMER};
      run_q  <= 1'b0;
      stop_d <= 1'b0;
    end else begin
      if (cfg_we && !run_q) cfg_q <= cfg_new;
      if (run_we) run_q <= run_wdata;
      stop_d <= stop_evt && (cfg_q.mode == MODE_ONESHOT);
    end
  end

  assign mode_enter = cfg_we && !run_q && (cfg_new.mode == MODE_ONESHOT) &&
                      (cfg_q.mode != MODE_ONESHOT);

  os_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_trig),
    .rise_o (ext_rise)
  );

  assign trig_sel = cfg_q.trig_ext ? ext_rise : sw_trig;

  os_count_core #(.W(W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_eff),
    .stop_i      (stop_evt),
    .trig_i      (trig_sel),
    .tick_i      (tick),
    .rld_we_i    (reload_we),
    .rld_wdata_i (reload_wdata),
    .view_o      (cnt_view),
    .active_o    (pulse_o),
    .zero_end_o  (zero_end)
  );

  assign irq_set = zero_end || stop_d || mode_enter;

  os_irq_flag u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .flag_o (irq_o)
  );

  assign pulse_oe = !(cfg_q.cut_en && !cut_n);
endmodule

// File: rtl/os_timer_chk.sv
module os_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_q,
  input logic         stop_evt,
  input logic         tick,
  input logic         pulse_o,
  input logic         irq_o,
  input logic         irq_clr,
  input logic         irq_set,
  input logic [3:0]   cfg_q,
  input logic [W-1:0] cnt_view
);
  // R3
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !pulse_o);

  // R3
  stop_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && cfg_q[1:0] == 2'b10) |=> ##1 irq_o);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(cfg_q));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !irq_o);

  // R4
  tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !stop_evt) |=> $stable(pulse_o));

  // R5
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pulse_o) && run_q && !stop_evt && $past(run_q)) |-> (irq_o && cnt_view == '0));
endmodule

bind oneshot_timer os_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .stop_evt (stop_evt),
  .tick     (tick),
  .pulse_o  (pulse_o),
  .irq_o    (irq_o),
  .irq_clr  (irq_clr),
  .irq_set  (irq_set),
  .cfg_q    (cfg_q),
  .cnt_view (cnt_view)
);

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;
  localparam int PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, run_we = 0, run_wdata = 0, reload_we = 0;
  logic [3:0] cfg_wdata = '0;
  logic [W-1:0] reload_wdata = '0;
  logic sw_trig = 0, ext_trig = 0, tick = 0, cut_n = 1, irq_clr = 0;
  logic [W-1:0] cnt_view;
  logic pulse_o, pulse_oe, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string tag; int sel; logic [W-1:0] exp; } item_t;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  oneshot_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .run_we(run_we), .run_wdata(run_wdata), .reload_we(reload_we),
    .reload_wdata(reload_wdata), .sw_trig(sw_trig), .ext_trig(ext_trig),
    .tick(tick), .cut_n(cut_n), .irq_clr(irq_clr), .cnt_view(cnt_view),
    .pulse_o(pulse_o), .pulse_oe(pulse_oe), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      wait (q.size() != 0);
      begin
        item_t it;
        logic [W-1:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = W'(pulse_o);
          1: act = W'(irq_o);
          2: act = cnt_view;
          default: act = W'(pulse_oe);
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input int sel, input logic [W-1:0] exp);
    q.push_back('{tag, sel, exp});
    #1;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tk();
    tick = 1; cyc(); tick = 0;
  endtask

  task automatic strobe_trig();
    sw_trig = 1; cyc(); sw_trig = 0;
  endtask

  task automatic wr_cfg(input logic [3:0] v);
    cfg_we = 1; cfg_wdata = v; cyc(); cfg_we = 0;
  endtask

  task automatic wr_run(input logic v);
    run_we = 1; run_wdata = v; cyc(); run_we = 0;
  endtask

  task automatic wr_reload(input logic [W-1:0] v);
    reload_we = 1; reload_wdata = v; cyc(); reload_we = 0;
  endtask

  task automatic clr_irq();
    irq_clr = 1; cyc(); irq_clr = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 pulse", 0, 0);
    chk("R1 irq", 1, 0);
    chk("R1 view", 2, 0);
    chk("R10 oe idle", 3, 1);

    // R7 load while stopped
    wr_reload(16'd3);
    chk("R7 loaded value", 2, 16'd3);

    // R6 enter one-shot: cut_en=1, sw trigger, mode 10
    wr_cfg(4'b1010);
    chk("R6 entry irq", 1, 1);
    clr_irq();
    chk("R9 clear", 1, 0);

    // R1 no pulse while stopped
    strobe_trig(); tk(); tk();
    chk("R1 stopped no pulse", 0, 0);

    // R2 cfg write while running is ignored
    wr_run(1);
    wr_cfg(4'b0000);
    chk("R2 no mode irq", 1, 0);

    // R4 trigger waits for tick
    strobe_trig(); cyc(); cyc();
    chk("R4 no tick no pulse", 0, 0);
    tick = 1; #1;
    chk("R7 view at start reload", 2, 16'hFFFF);
    cyc(); tick = 0;
    chk("R5 pulse high", 0, 1);
    chk("R5 loaded", 2, 16'd3);
    tk(); chk("R5 count 2", 2, 16'd2);
    tk(); chk("R5 count 1", 2, 16'd1);
    chk("R5 still high", 0, 1);
    tk();
    chk("R5 pulse low", 0, 0);
    chk("R5 zero", 2, 16'd0);
    chk("R5 irq", 1, 1);
    clr_irq();
    chk("R9 cleared", 1, 0);

    // R3 stop during pulse
    strobe_trig(); tk();
    chk("R3 pulse before stop", 0, 1);
    run_we = 1; run_wdata = 0; #1;
    chk("R7 view at stop", 2, 16'hFFFF);
    cyc(); run_we = 0;
    chk("R3 pulse low", 0, 0);
    chk("R3 reloaded", 2, 16'd3);
    chk("R3 irq not yet", 1, 0);
    irq_clr = 1; cyc(); irq_clr = 0;
    chk("R9 set wins over clear", 1, 1);
    clr_irq();

    // R8 retrigger
    wr_reload(16'd4);
    wr_run(1);
    strobe_trig(); tk();
    chk("R8 start 4", 2, 16'd4);
    tk(); chk("R8 count 3", 2, 16'd3);
    strobe_trig();
    tk(); chk("R8 extra decrement", 2, 16'd2);
    strobe_trig();
    tk(); chk("R8 reload", 2, 16'd4);
    chk("R8 pulse held", 0, 1);
    tk(); chk("R8 blank trigger ignored", 2, 16'd3);
    tk(); tk(); tk();
    chk("R8 end low", 0, 0);
    chk("R8 end irq", 1, 1);

    // R11 external trigger source
    wr_run(0); cyc(); cyc();
    clr_irq();
    wr_cfg(4'b1110);
    chk("R6 rewrite no irq", 1, 0);
    wr_run(1);
    strobe_trig(); tk();
    chk("R11 sw ignored", 0, 0);
    ext_trig = 1;
    cyc(); cyc(); cyc();
    chk("R4 ext before tick", 0, 0);
    tk();
    chk("R11 ext pulse", 0, 1);

    // R10 cutoff
    cut_n = 0; #1;
    chk("R10 cutoff oe", 3, 0);
    cut_n = 1; #1;
    chk("R10 released oe", 3, 1);

    cyc();
    done = 1;
    report();
  end
endmodule